// File: doc/BRIEF.md
# Vector Rounding Shift-Narrow Unit

This block is one stage of a 256-bit SIMD datapath. Every wide element of the source vector is shifted right by its own amount, rounded to nearest, and cut down to half its width. The logical flavour fills the vacated bits with zeros. The arithmetic flavour fills them with copies of the sign bit. The shift amount for a lane comes from the element at the same position in a second vector.

The vector is treated as two independent 128-bit halves. The narrowed results of each half are packed into that half's low 64 bits, and the half's upper 64 bits are cleared. In 128-bit mode only the lower half is computed and the whole upper half of the result reads zero.

A single register stage holds the result. The result and its valid flag are captured on the clock edge where the input valid is high. The result is held while no new operation is presented.

Top module: `vec_rnd_shr_narrow`

## Requirements
- R1: `size_i` selects the element sizes. Code 0 takes 16-bit elements to 8-bit results, code 1 takes 32 bits to 16, and code 2 takes 64 bits to 32. Code 3 is reserved and produces an all-zero result.
- R2: Each lane's shift amount is the low log2(SW) bits of the same-position SW-bit element of `vk_i`. This is the unsigned element value modulo SW, so a value of 17 on a 16-bit lane shifts by 1.
- R3: When `arith_i` is 0 the shift fills with zeros. When `arith_i` is 1 the shift fills with the sign bit of the source element.
- R4: For a nonzero shift amount s, bit s-1 of the unshifted source is added to the shifted value. A shift of 0 passes the element through with no increment. The result keeps the low SW/2 bits of the rounded value and wraps without saturating (logical 16'hFFFF shifted by 1 gives 8'h00).
- R5: Narrowed lane i of the lower half lands at bits i*SW/2 upward. Lane i of the upper half lands at bits 128+i*SW/2 upward.
- R6: Bits 127:64 and bits 255:192 of `vd_o` are always zero.
- R7: When `wide_i` is 0, bits 255:128 of the captured result are zero whatever `vj_i` and `vk_i` hold.
- R8: `valid_o` equals `valid_i` of the previous clock. When `valid_i` was high, `vd_o` shows that operation's result one clock later.
- R9: While `valid_i` is low, `vd_o` keeps its previous value.
- R10: After reset `valid_o` is 0 and `vd_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| arith_i | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| size_i | input | 2 | Element size code (see R1) |
| wide_i | input | 1 | 1 = 256-bit mode, 0 = 128-bit mode |
| vj_i | input | 256 | Source vector |
| vk_i | input | 256 | Per-lane shift-amount vector |
| valid_o | output | 1 | Result register valid |
| vd_o | output | 256 | Packed narrowed result |

## Verification
The assertions assume that `valid_i`, `size_i`, `wide_i` and `arith_i` are known at every clock edge once reset is released. They also assume that the data vectors are fully driven whenever `valid_i` is high.

The bench drives every input at the falling edge from a single process, so each value is settled before the edge that captures it. Operations are mixed with idle cycles that carry random data, which makes the hold rule observable. The stimulus covers all four size codes, both shift flavours and both widths. Directed patterns hit shift amounts of zero, the maximum, values that exceed the element width, and roundings that wrap.

// File: rtl/vrsn_pkg.sv
package vrsn_pkg;
  typedef enum logic [1:0] {
    SZ_H2B = 2'd0,
    SZ_W2H = 2'd1,
    SZ_D2W = 2'd2,
    SZ_RSV = 2'd3
  } size_e;

  localparam int unsigned NUM_SZ  = 3;
  localparam int unsigned MIN_SW  = 16;
endpackage

// File: rtl/vrsn_lane.sv
module vrsn_lane #(
  parameter int unsigned SW = 16,
  localparam int unsigned NW = SW / 2,
  localparam int unsigned AW = $clog2(SW)
) (
  input  logic [SW-1:0] src_i,
  input  logic [SW-1:0] amt_i,
  input  logic          arith_i,
  output logic [NW-1:0] res_o
);
  logic [AW-1:0] sh;
  logic [AW-1:0] rnd_idx;
  logic [SW-1:0] shr;
  logic [SW-1:0] sum;
  logic          rnd;

  assign sh      = amt_i[AW-1:0];  // modulo element width
  assign rnd_idx = sh - 1'b1;

  always_comb begin
    if (arith_i) shr = $unsigned($signed(src_i) >>> sh);
    else         shr = src_i >> sh;
    rnd = (sh == '0) ? 1'b0 : src_i[rnd_idx];
    sum = shr + SW'(rnd);
  end

  assign res_o = sum[NW-1:0];
endmodule

// File: rtl/vrsn_half.sv
module vrsn_half
  import vrsn_pkg::*;
#(
  parameter int unsigned HW = 128,
  localparam int unsigned PW = HW / 2
) (
  input  logic [HW-1:0] src_i,
  input  logic [HW-1:0] amt_i,
  input  logic          arith_i,
  input  logic [1:0]    size_i,
  output logic [PW-1:0] pack_o
);
  logic [NUM_SZ-1:0][PW-1:0] cand;

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int unsigned SW = MIN_SW << g;
    localparam int unsigned NW = SW / 2;
    localparam int unsigned NL = HW / SW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      vrsn_lane #(.SW(SW)) i_lane (
        .src_i  (src_i[l*SW +: SW]),
        .amt_i  (amt_i[l*SW +: SW]),
        .arith_i(arith_i),
        .res_o  (cand[g][l*NW +: NW])
      );
    end
  end

  always_comb begin
    unique case (size_e'(size_i))
      SZ_H2B:  pack_o = cand[0];
      SZ_W2H:  pack_o = cand[1];
      SZ_D2W:  pack_o = cand[2];
      default: pack_o = '0;
    endcase
  end
endmodule

// File: rtl/vec_rnd_shr_narrow.sv
module vec_rnd_shr_narrow #(
  parameter int unsigned VW = 256,
  localparam int unsigned HW = 128,
  localparam int unsigned NH = VW / HW,
  localparam int unsigned PW = HW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          arith_i,
  input  logic [1:0]    size_i,
  input  logic          wide_i,
  input  logic [VW-1:0] vj_i,
  input  logic [VW-1:0] vk_i,
  output logic          valid_o,
  output logic [VW-1:0] vd_o
);
  logic [VW-1:0] vd_d;
  logic [VW-1:0] vd_q;
  logic          valid_q;

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [PW-1:0] pack;
    logic          en;
    assign en = (h == 0) || wide_i;
    vrsn_half #(.HW(HW)) i_half (
      .src_i  (vj_i[h*HW +: HW]),
      .amt_i  (vk_i[h*HW +: HW]),
      .arith_i(arith_i),
      .size_i (size_i),
      .pack_o (pack)
    );
    assign vd_d[h*HW +: HW] = {{PW{1'b0}}, en ? pack : {PW{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vd_q    <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) vd_q <= vd_d;
    end
  end

  assign valid_o = valid_q;
  assign vd_o    = vd_q;
endmodule

// File: rtl/vrsn_checker.sv
module vrsn_checker (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         arith_i,
  input logic [1:0]   size_i,
  input logic         wide_i,
  input logic [255:0] vj_i,
  input logic [255:0] vk_i,
  input logic         valid_o,
  input logic [255:0] vd_o
);
  p_pad_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vd_o[127:64] == '0) && (vd_o[255:192] == '0));

  p_narrow_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> vd_o[255:128] == '0);

  p_valid_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(vd_o));

  p_zero_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == 2'd0 && vk_i[3:0] == 4'd0
      |=> vd_o[7:0] == $past(vj_i[7:0]));

  p_reserved_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == 2'd3 |=> vd_o == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r10: assert (!valid_o && vd_o == '0);
    end
  end
endmodule

bind vec_rnd_shr_narrow vrsn_checker i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .arith_i(arith_i),
  .size_i (size_i),
  .wide_i (wide_i),
  .vj_i   (vj_i),
  .vk_i   (vk_i),
  .valid_o(valid_o),
  .vd_o   (vd_o)
);

// File: tb/test_vec_rnd_shr_narrow.sv
module test_vec_rnd_shr_narrow;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         arith_i = 1'b0;
  logic [1:0]   size_i = 2'd0;
  logic         wide_i = 1'b0;
  logic [255:0] vj_i = '0;
  logic [255:0] vk_i = '0;
  logic         valid_o;
  logic [255:0] vd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [255:0] exp_vd = '0;
  logic         exp_valid = 1'b0;

  always #5 clk = ~clk;

  vec_rnd_shr_narrow i_vec_rnd_shr_narrow (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .arith_i(arith_i),
    .size_i(size_i), .wide_i(wide_i), .vj_i(vj_i), .vk_i(vk_i),
    .valid_o(valid_o), .vd_o(vd_o)
  );

  function automatic logic [255:0] ref_out(bit ar, int sz, bit wd,
                                           logic [255:0] a, logic [255:0] k);
    logic [255:0] r;
    r = '0;
    if (sz > 2) return r;
    for (int h = 0; h < (wd ? 2 : 1); h++) begin
      for (int i = 0; i < 128 / (16 << sz); i++) begin
        int sw, nw, base, sh;
        logic [127:0] s, shf;
        logic rb;
        sw = 16 << sz;
        nw = sw / 2;
        base = h * 128 + i * sw;
        s = '0;
        for (int b = 0; b < sw; b++) s[b] = a[base + b];
        if (ar && s[sw-1]) for (int b = sw; b < 128; b++) s[b] = 1'b1;
        sh = int'(k[base +: 8]) % sw;
        shf = ar ? $unsigned($signed(s) >>> sh) : s >> sh;
        rb = (sh == 0) ? 1'b0 : s[sh-1];
        shf = shf + 128'(rb);
        for (int b = 0; b < nw; b++) r[h*128 + i*nw + b] = shf[b];
      end
    end
    return r;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (valid_o !== exp_valid || vd_o !== exp_vd) begin
      n_bad++;
      $display("FAIL %s: valid %0b vd %h, expected valid %0b vd %h",
               tag, valid_o, vd_o, exp_valid, exp_vd);
    end
  endtask

  task automatic step(string tag, bit v, bit ar, int sz, bit wd,
                      logic [255:0] a, logic [255:0] k);
    valid_i = v; arith_i = ar; size_i = 2'(sz); wide_i = wd;
    vj_i = a; vk_i = k;
    @(posedge clk);
    exp_valid = v;
    if (v) exp_vd = ref_out(ar, sz, wd, a, k);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 after release");
    // R4 wrap: 0xFFFF >> 1 rounds to 0x8000, low byte 00
    step("R4 wrap", 1, 0, 0, 1, {16{16'hFFFF}}, {16{16'h0001}});
    // R4 zero shift passes through
    step("R4 zero shift", 1, 0, 1, 1, {8{32'h1234_5678}}, '0);
    // R2 modulo: 17 on 16-bit lane is shift 1, 33 on 32-bit is shift 1
    step("R2 modulo h", 1, 0, 0, 1, {16{16'h0103}}, {16{16'h0011}});
    step("R2 modulo w", 1, 1, 1, 1, {8{32'h8000_0003}}, {8{32'h0000_0021}});
    // R3 arithmetic vs logical on negative elements
    step("R3 logical", 1, 0, 2, 1, {4{64'hF000_0000_0000_0001}}, {4{64'd60}});
    step("R3 arith", 1, 1, 2, 1, {4{64'hF000_0000_0000_0001}}, {4{64'd60}});
    step("R3 arith max", 1, 1, 0, 1, {16{16'hC000}}, {16{16'h000F}});
    // R5 distinct lanes
    step("R5 lanes", 1, 0, 0, 1,
         {16'hF000, 16'hE000, 16'hD000, 16'hC000, 16'hB000, 16'hA000, 16'h9000, 16'h8000,
          16'h7000, 16'h6000, 16'h5000, 16'h4000, 16'h3000, 16'h2000, 16'h1000, 16'h0100},
         {16{16'h0008}});
    // R7 128-bit mode with busy upper input
    step("R7 narrow mode", 1, 1, 1, 0, {256{1'b1}}, {8{32'h0000_0004}});
    // R1 reserved code
    step("R1 reserved", 1, 0, 3, 1, rnd256(), rnd256());
    // R9 idle with changing data
    for (int i = 0; i < 4; i++) step("R9 hold", 0, 1, i % 3, 1, rnd256(), rnd256());
    // R8 back-to-back and R1/R6 random sweep
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step("R8 random", v, 1'($urandom), int'($urandom % 4), 1'($urandom),
           rnd256(), rnd256());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule